// File: doc/BRIEF.md
# Cyclic Gas Burner Phase Controller

This block sequences a single gas burner through four phases (idle, purge, ignite, burn) and opens the gas valve only while igniting or burning. A heat request from a thermostat starts a cycle. A purge interval with the valve shut comes first, then a short ignition window with the valve open. Burning then continues for as long as both the flame sensor and the heat request stay asserted.

All timing is counted in ticks of an external strobe (nominally 10 per second). Inputs are examined only on cycles where the strobe is high, so each transition takes effect on the first tick at which its condition holds. That bounds the reaction time to one tick. A dwell counter restarts on every phase change and sets the length of the purge and ignite phases. The current phase is driven out as a 2-bit code for observation.

Top module: `gas_burner_ctrl`

## Requirements
- R1: While rst_ni is low and after it is released, phase_o is 00 (idle) and gas_o is 0 until the first qualifying tick.
- R2: The phase codes are idle 00, purge 01, ignite 10 and burn 11. The phase changes only on a rising clk edge with tick_i high, and only to the next code in the cycle 00, 01, 10, 11, 00.
- R3: gas_o is 1 exactly when phase_o is 10 or 11, and 0 in 00 and 01.
- R4: In idle, a tick with heat_req_i high moves the controller to purge. A tick with heat_req_i low leaves it in idle.
- R5: Purge moves to ignite on the PURGE_TICKS-th tick after purge was entered, whatever heat_req_i and flame_i are. The default is 300 ticks, which is 30 s at 10 ticks per second.
- R6: Ignite moves to burn on the IGNITE_TICKS-th tick after ignite was entered, whatever the inputs are. The default is 10 ticks (1 s).
- R7: In burn, a tick with flame_i low or heat_req_i low returns the controller to idle. Flame loss is tested first. A tick with both inputs high keeps it in burn.
- R8: heat_req_i and flame_i have no effect on cycles where tick_i is low, and such cycles do not advance the dwell count.
- R9: The dwell count restarts on every phase entry, so every purge and ignite visit has the full length, including later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base strobe, one cycle wide per tick |
| heat_req_i | input | 1 | Thermostat heat request |
| flame_i | input | 1 | Flame sensor, 1 when a flame is present |
| gas_o | output | 1 | Gas valve open |
| phase_o | output | 2 | Current phase code (00 idle, 01 purge, 10 ignite, 11 burn) |

## Verification
The assertions assume the inputs are synchronous to clk_i and hold known values once reset is released. They do not require tick_i to be isolated, but the timing checks count every high cycle of tick_i as one tick. The stimulus changes the inputs only at falling edges. It drives tick_i high for one cycle at a time, and between ticks it fills the gaps with opposing heat and flame values so that ignoring non-tick cycles is visible. It uses short dwell limits so that every dwell count and every burn exit combination is covered across several full cycles.

// File: rtl/gb_pkg.sv
package gb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'b00,
    PH_PURGE  = 2'b01,
    PH_IGNITE = 2'b10,
    PH_BURN   = 2'b11
  } phase_e;
endpackage

// File: rtl/gb_dwell_timer.sv
module gb_dwell_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (run_i && tick_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign expire_o = run_i && tick_i && (cnt_q == limit_i - CNT_W'(1));

  // R5 R6
  dwell_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < limit_i));

  // R8
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/gb_phase_fsm.sv
module gb_phase_fsm
  import gb_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  input  logic   heat_req_i,
  input  logic   flame_i,
  input  logic   expire_i,
  output phase_e phase_o,
  output logic   change_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (tick_i) begin
      unique case (phase_q)
        PH_IDLE:   if (heat_req_i) phase_d = PH_PURGE;
        PH_PURGE:  if (expire_i)   phase_d = PH_IGNITE;
        PH_IGNITE: if (expire_i)   phase_d = PH_BURN;
        PH_BURN: begin
          if (!flame_i)         phase_d = PH_IDLE;  // flame loss checked first
          else if (!heat_req_i) phase_d = PH_IDLE;
        end
        default:                phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o  = phase_q;
  assign change_o = (phase_d != phase_q);

  // R2
  cyclic_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != $past(phase_q)) |-> (2'(phase_q) == 2'($past(phase_q) + 2'd1)));

  // R2 R8
  tick_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(phase_q));

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && !heat_req_i) |=> (phase_q == PH_IDLE));

  // R7
  burn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_BURN && heat_req_i && flame_i) |=> (phase_q == PH_BURN));

  // R7
  burn_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_BURN && tick_i && !(heat_req_i && flame_i)) |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/gas_burner_ctrl.sv
module gas_burner_ctrl
  import gb_pkg::*;
#(
  parameter int PURGE_TICKS  = 300,
  parameter int IGNITE_TICKS = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       heat_req_i,
  input  logic       flame_i,
  output logic       gas_o,
  output logic [1:0] phase_o
);
  localparam int MAX_TICKS = (PURGE_TICKS > IGNITE_TICKS) ? PURGE_TICKS : IGNITE_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  phase_e           phase;
  logic             change, expire, run;
  logic [CNT_W-1:0] limit;

  assign run   = (phase == PH_PURGE) || (phase == PH_IGNITE);
  assign limit = (phase == PH_PURGE) ? CNT_W'(PURGE_TICKS) : CNT_W'(IGNITE_TICKS);

  gb_phase_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .heat_req_i (heat_req_i),
    .flame_i    (flame_i),
    .expire_i   (expire),
    .phase_o    (phase),
    .change_o   (change)
  );

  gb_dwell_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (change),
    .run_i    (run),
    .tick_i   (tick_i),
    .limit_i  (limit),
    .expire_o (expire)
  );

  assign gas_o   = (phase == PH_IGNITE) || (phase == PH_BURN);
  assign phase_o = phase;

  // R3
  gas_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gas_o) |-> (phase_o == 2'b10 && $past(phase_o) == 2'b01));

  // R3
  gas_shut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gas_o) |-> (phase_o == 2'b00));
endmodule

// File: tb/test_gas_burner_ctrl.sv
module test_gas_burner_ctrl;
  localparam int PT = 6;
  localparam int IT = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, heat = 1'b0, flame = 1'b0;
  logic       gas;
  logic [1:0] phase;

  int vectors = 0;
  int errors  = 0;
  int m_ph    = 0;
  int m_cnt   = 0;

  always #5 clk = ~clk;

  gas_burner_ctrl #(.PURGE_TICKS(PT), .IGNITE_TICKS(IT)) i_gas_burner_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .heat_req_i(heat),
    .flame_i(flame), .gas_o(gas), .phase_o(phase)
  );

  task automatic check(input string tag);
    vectors++;
    if (phase !== 2'(m_ph)) begin
      errors++;
      $display("FAIL %s phase act=%b exp=%b", tag, phase, 2'(m_ph));
    end
    vectors++;
    if (gas !== (m_ph >= 2)) begin
      errors++;
      $display("FAIL R3 gas act=%b exp=%b", gas, (m_ph >= 2));
    end
  endtask

  // one tick cycle followed by two non-tick cycles carrying opposite inputs
  task automatic step(input logic h, input logic f);
    string tag;
    int    prev;
    prev = m_ph;
    case (m_ph)
      0: tag = "R4";
      1: tag = "R5";
      2: tag = "R6";
      default: tag = "R7";
    endcase
    @(negedge clk); tick = 1'b1; heat = h; flame = f;
    @(posedge clk);
    case (m_ph)
      0: if (h) begin m_ph = 1; m_cnt = 0; end
      1: begin m_cnt++; if (m_cnt == PT) begin m_ph = 2; m_cnt = 0; end end
      2: begin m_cnt++; if (m_cnt == IT) begin m_ph = 3; m_cnt = 0; end end
      default: if (!f || !h) m_ph = 0;
    endcase
    #2;
    if (m_ph != prev) tag = {tag, " R2 R9"};
    check(tag);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); tick = 1'b0; heat = ~h; flame = ~f;
      @(posedge clk); #2;
      check("R8");
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2; check("R1");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2; check("R1");
    // heat pulses without tick: stays idle
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); heat = 1'b1; flame = 1'b1;
      @(posedge clk); #2; check("R8");
    end
    for (int k = 0; k < 3; k++) step(1'b0, k[0]);
    // four full cycles, one per burn exit pattern; last pattern stays then exits
    for (int c = 0; c < 4; c++) begin
      step(1'b1, 1'b0);
      for (int k = 0; k < PT + IT; k++) step(k[0], k[1]);
      for (int k = 0; k < c + 1; k++) step(1'b1, 1'b1);
      case (c)
        0: step(1'b0, 1'b0);
        1: step(1'b1, 1'b0);
        2: step(1'b0, 1'b1);
        default: step(1'b1, 1'b0);
      endcase
      step(1'b0, 1'b1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule